// File: doc/BRIEF.md
# Indexed RTC Register Port

This block is the host-facing register front end of a real-time clock. A host reaches a 128-byte register space through two byte addresses. A write to the even address selects a location. Reads and writes at the odd address then act on that location. The block holds the clock's control and status bytes, the seven visible time and date bytes, and plain storage for everything else. The seconds counter and the periodic rate divider sit outside the block. They report through event pulses (update start, update done, alarm match, periodic tick), supply the counted time on each update, and receive a load request whenever software changes the visible time.

Requests enter on a valid/ready channel: a request transfers on a cycle where `req_valid` and `req_ready` are both high. Read data leaves on a valid/ready response channel. A read is answered one cycle after it is accepted. The response holds steady until `rsp_ready` is seen high. While a response is still waiting, `req_ready` stays low, so at most one read is ever outstanding. Writes produce no response.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (`req_addr`=0) stores `req_wdata[6:0]` as the current index. A read from the even address returns 0xFF.
- R2: Control byte A sits at index 10. Its bit 7 is an update-in-progress flag that writes cannot change; a write to A stores bits 6:0 only. The flag is set by `upd_start` while set mode is off, and cleared by `upd_done`.
- R3: Control byte B sits at index 11, with bit 7 = set mode, 6 = periodic enable, 5 = alarm enable, 4 = update enable, 3 = square-wave enable, 2 = binary data mode, 1 = 24-hour mode. A write to B with bit 7 = 1 clears the update-in-progress flag and stores bit 4 as 0.
- R4: A write to B with bit 7 = 0, made while set mode was on, raises `load_pulse` for one cycle. At that point `load_time` carries the visible time bytes. A write to B while set mode was already off raises no load.
- R5: The time bytes sit at indices 0, 2, 4, 6, 7, 8, 9 (second, minute, hour, weekday, day, month, year). They map to `load_time`/`cnt_time` byte slots 0 to 6, with slot k at bits 8k+7:8k. A write to one of them stores the byte. When set mode is off, `load_pulse` follows one cycle later; when set mode is on, no load is raised.
- R6: Flag byte C (index 12) and status byte D (index 13) ignore writes. D always reads 0x80. A read of C returns its value, clears it to 0x00 and drops `irq`, unless an event arrives in that same cycle.
- R7: Byte C has bit 6 = periodic flag, 5 = alarm flag, 4 = update-ended flag, and bits 3:0 read 0. Bit 7 and the `irq` pin are the OR of each flag ANDed with its enable in B, so a flag raised while its enable is off does not assert `irq` until the enable is set.
- R8: After `rst_n` the block reads A = 0x26, B = 0x02, C = 0x00, D = 0x80, with `irq` low.
- R9: A `soft_rst` pulse clears B bits 6, 5 and 3, clears all flags in C and drops `irq`. Other bytes keep their values.
- R10: `upd_done` always sets the update-ended flag. When set mode is off, it also copies `cnt_time` into the visible time bytes; when set mode is on, the visible bytes keep their values.
- R11: While a response is pending and `rsp_ready` is low, `rsp_valid` stays high, `rsp_data` stays stable and `req_ready` is low.
- R12: Every other index, the alarm bytes 1, 3 and 5 included, is plain byte storage that reads back the last value written and raises no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| soft_rst | input | 1 | Synchronous pulse that clears enables and flags |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = index address, 1 = data address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8 | Read response data |
| upd_start | input | 1 | Counter begins a one-second update |
| upd_done | input | 1 | Counter finished an update |
| cnt_time | input | 56 | Counted time, seven byte slots |
| alarm_hit | input | 1 | Alarm match event |
| per_tick | input | 1 | Periodic rate event |
| ctrl_a | output | 8 | Current control byte A |
| ctrl_b | output | 8 | Current control byte B |
| load_pulse | output | 1 | Request to load the counter from `load_time` |
| load_time | output | 56 | Visible time bytes, seven slots |
| irq | output | 1 | Interrupt, high while any enabled flag is set |

## Verification
On every cycle, the assertions cover the protected update-in-progress bit across A writes, the bits that set mode forces in B and A, the drop of the interrupt after a clearing read of C, the gating of load requests by set mode, the response hold under back-pressure, the soft-reset clearing, and the 0xFF answer at the even address. Only the bench scenarios can show values carried across several transactions. These are the byte captured at each load, the visible time that holds or follows the counter depending on set mode, the exact flag patterns read back from C, the interrupt appearing late when an enable is turned on after its flag, and the storage behaviour of the general bytes.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int IDX_W     = 7;
  localparam int NUM_REGS  = 1 << IDX_W;
  localparam int DW        = 8;
  localparam int SLOTS     = 7;
  localparam int SLOT_W    = $clog2(SLOTS);

  localparam logic [IDX_W-1:0] IDX_A = 7'd10;
  localparam logic [IDX_W-1:0] IDX_B = 7'd11;
  localparam logic [IDX_W-1:0] IDX_C = 7'd12;
  localparam logic [IDX_W-1:0] IDX_D = 7'd13;

  localparam int A_UIP  = 7;
  localparam int B_SET  = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;
  localparam int B_SQWE = 3;

  localparam logic [DW-1:0] A_INIT = 8'h26;
  localparam logic [DW-1:0] B_INIT = 8'h02;
  localparam logic [DW-1:0] D_VAL  = 8'h80;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } tslot_t;

  function automatic tslot_t decode_slot(input logic [IDX_W-1:0] idx);
    tslot_t r;
    r.hit = 1'b1;
    case (idx)
      7'd0:    r.slot = 3'd0;
      7'd2:    r.slot = 3'd1;
      7'd4:    r.slot = 3'd2;
      7'd6:    r.slot = 3'd3;
      7'd7:    r.slot = 3'd4;
      7'd8:    r.slot = 3'd5;
      7'd9:    r.slot = 3'd6;
      default: begin r.hit = 1'b0; r.slot = 3'd0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] wdata,
  input  logic          rd_c,
  input  logic          upd_start,
  input  logic          upd_done,
  input  logic          alarm_hit,
  input  logic          per_tick,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic [DW-1:0] reg_c,
  output logic          set_cleared,
  output logic          irq
);
  logic [DW-2:0] a_low;
  logic          uip;
  logic [DW-1:0] b_q;
  logic [2:0]    flags;   // periodic, alarm, update-ended
  logic [2:0]    enables;
  logic          irq_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_low <= A_INIT[DW-2:0];
      uip   <= 1'b0;
      b_q   <= B_INIT;
      flags <= '0;
    end else begin
      if (wr_a) a_low <= wdata[DW-2:0];

      if (wr_b && wdata[B_SET]) uip <= 1'b0;
      else if (upd_done)        uip <= 1'b0;
      else if (upd_start && !b_q[B_SET]) uip <= 1'b1;

      if (soft_rst) begin
        b_q[B_PIE]  <= 1'b0;
        b_q[B_AIE]  <= 1'b0;
        b_q[B_SQWE] <= 1'b0;
        flags       <= '0;
      end else begin
        if (wr_b) begin
          b_q        <= wdata;
          b_q[B_UIE] <= wdata[B_UIE] & ~wdata[B_SET];
        end
        flags <= (rd_c ? 3'b000 : flags) | {per_tick, alarm_hit, upd_done};
      end
    end
  end

  assign enables     = {b_q[B_PIE], b_q[B_AIE], b_q[B_UIE]};
  assign irq_any     = |(flags & enables);
  assign reg_a       = {uip, a_low};
  assign reg_b       = b_q;
  assign reg_c       = {irq_any, flags, 4'b0000};
  assign set_cleared = wr_b && !wdata[B_SET] && b_q[B_SET];
  assign irq         = irq_any;
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_regport_pkg::*;
#(
  parameter int N_SLOTS = SLOTS,
  parameter int BW      = DW,
  localparam int SW     = $clog2(N_SLOTS)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_slot,
  input  logic [BW-1:0]        wdata,
  input  logic                 cap_en,
  input  logic [N_SLOTS*BW-1:0] cap_time,
  input  logic                 load_req,
  output logic [N_SLOTS*BW-1:0] time_q,
  output logic                 load_pulse
);
  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              time_q[k*BW +: BW] <= '0;
      else if (wr_en && wr_slot == SW'(k))     time_q[k*BW +: BW] <= wdata;
      else if (cap_en)                         time_q[k*BW +: BW] <= cap_time[k*BW +: BW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_pulse <= 1'b0;
    else        load_pulse <= load_req;
  end
endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
  parameter int DEPTH = 128,
  parameter int BW    = 8,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [BW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [BW-1:0] rdata
);
  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DW-1:0]      rsp_data,
  input  logic               upd_start,
  input  logic               upd_done,
  input  logic [SLOTS*DW-1:0] cnt_time,
  input  logic               alarm_hit,
  input  logic               per_tick,
  output logic [DW-1:0]      ctrl_a,
  output logic [DW-1:0]      ctrl_b,
  output logic               load_pulse,
  output logic [SLOTS*DW-1:0] load_time,
  output logic               irq
);
  logic [IDX_W-1:0] idx_q;
  logic             req_fire, wr_fire, rd_fire;
  logic             wr_dat, wr_a, wr_b, rd_c;
  logic             is_ctl, ram_we, time_we, load_req, set_cleared;
  tslot_t           tsel;
  logic [DW-1:0]    reg_a, reg_b, reg_c, ram_rdata, rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign wr_fire   = req_fire && req_write;
  assign rd_fire   = req_fire && !req_write;
  assign wr_dat    = wr_fire && req_addr;

  assign tsel    = decode_slot(idx_q);
  assign is_ctl  = (idx_q == IDX_A) || (idx_q == IDX_B) ||
                   (idx_q == IDX_C) || (idx_q == IDX_D);
  assign wr_a    = wr_dat && (idx_q == IDX_A);
  assign wr_b    = wr_dat && (idx_q == IDX_B);
  assign rd_c    = rd_fire && req_addr && (idx_q == IDX_C);
  assign time_we = wr_dat && tsel.hit;
  assign ram_we  = wr_dat && !tsel.hit && !is_ctl;
  assign load_req = (time_we && !reg_b[B_SET]) || set_cleared;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idx_q <= '0;
    else if (wr_fire && !req_addr) idx_q <= req_wdata[IDX_W-1:0];
  end

  rtc_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_a(wr_a), .wr_b(wr_b), .wdata(req_wdata), .rd_c(rd_c),
    .upd_start(upd_start), .upd_done(upd_done),
    .alarm_hit(alarm_hit), .per_tick(per_tick),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .set_cleared(set_cleared), .irq(irq)
  );

  rtc_time_regs #(.N_SLOTS(SLOTS), .BW(DW)) u_time (
    .clk(clk), .rst_n(rst_n),
    .wr_en(time_we), .wr_slot(tsel.slot), .wdata(req_wdata),
    .cap_en(upd_done && !reg_b[B_SET]), .cap_time(cnt_time),
    .load_req(load_req), .time_q(load_time), .load_pulse(load_pulse)
  );

  rtc_scratch_ram #(.DEPTH(NUM_REGS), .BW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(idx_q), .wdata(req_wdata),
    .raddr(idx_q), .rdata(ram_rdata)
  );

  always_comb begin
    if (!req_addr)            rd_mux = '1;
    else if (idx_q == IDX_A)  rd_mux = reg_a;
    else if (idx_q == IDX_B)  rd_mux = reg_b;
    else if (idx_q == IDX_C)  rd_mux = reg_c;
    else if (idx_q == IDX_D)  rd_mux = D_VAL;
    else if (tsel.hit)        rd_mux = load_time[tsel.slot*DW +: DW];
    else                      rd_mux = ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign ctrl_a = reg_a;
  assign ctrl_b = reg_b;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wr_a,
  input logic       wr_b,
  input logic       rd_c,
  input logic       rd_fire,
  input logic       req_addr,
  input logic [7:0] req_wdata,
  input logic       upd_start,
  input logic       upd_done,
  input logic       alarm_hit,
  input logic       per_tick,
  input logic       irq,
  input logic [7:0] ctrl_a,
  input logic [7:0] ctrl_b,
  input logic       load_pulse,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data
);
  p_even_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && !req_addr |=> rsp_data == 8'hFF);

  p_uip_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && !upd_start && !upd_done |=> ctrl_a[7] == $past(ctrl_a[7]));

  p_set_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b && req_wdata[7] |=> !ctrl_a[7] && !ctrl_b[4]);

  p_load_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> !ctrl_b[7]);

  p_clear_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c && !upd_done && !alarm_hit && !per_tick |=> !irq);

  p_soft_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !irq && ctrl_b[6:5] == 2'b00 && !ctrl_b[3]);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .wr_a(wr_a), .wr_b(wr_b), .rd_c(rd_c), .rd_fire(rd_fire),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .upd_start(upd_start), .upd_done(upd_done),
  .alarm_hit(alarm_hit), .per_tick(per_tick), .irq(irq),
  .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .load_pulse(load_pulse),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/rtc_regport_test.sv
module rtc_regport_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_addr = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        upd_start = 1'b0, upd_done = 1'b0, alarm_hit = 1'b0, per_tick = 1'b0;
  logic [55:0] cnt_time = '0;
  logic [7:0]  ctrl_a, ctrl_b;
  logic        load_pulse;
  logic [55:0] load_time;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  int load_cnt = 0;
  logic [55:0] last_load = '0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  bit          reported = 0;

  always #5 clk = ~clk;

  rtc_regport uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .upd_start(upd_start), .upd_done(upd_done), .cnt_time(cnt_time),
    .alarm_hit(alarm_hit), .per_tick(per_tick),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
    .load_pulse(load_pulse), .load_time(load_time), .irq(irq)
  );

  // Monitor: pops the scoreboard on each response handshake.
  always @(negedge clk) begin
    if (rsp_valid && rsp_ready) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL unexpected response: actual %02h expected none", rsp_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          miscompares++;
          $display("FAIL %s: actual %02h expected %02h", t, rsp_data, e);
        end
      end
    end
    if (load_pulse) begin
      load_cnt++;
      last_load = load_time;
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic bus(input logic wr, input logic adr, input logic [7:0] d);
    logic ok;
    req_valid = 1'b1; req_write = wr; req_addr = adr; req_wdata = d;
    ok = 1'b0;
    while (!ok) begin
      @(negedge clk); ok = req_ready;
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
    bus(1'b1, 1'b0, idx);
    bus(1'b1, 1'b1, val);
  endtask

  task automatic rd_reg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    bus(1'b1, 1'b0, idx);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus(1'b0, 1'b1, 8'h00);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) step();
    step();
  endtask

  task automatic pulse(input int which);
    case (which)
      0: upd_start = 1'b1;
      1: upd_done  = 1'b1;
      2: alarm_hit = 1'b1;
      3: per_tick  = 1'b1;
      default: soft_rst = 1'b1;
    endcase
    step();
    upd_start = 1'b0; upd_done = 1'b0; alarm_hit = 1'b0; per_tick = 1'b0; soft_rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int lc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R8 power-up values
    chk("R8 irq after reset", irq, 0);
    rd_reg(8'd10, 8'h26, "R8 A init");
    rd_reg(8'd11, 8'h02, "R8 B init");
    rd_reg(8'd12, 8'h00, "R8 C init");
    rd_reg(8'd13, 8'h80, "R8 D init");
    // R1 even-address read
    exp_q.push_back(8'hFF); tag_q.push_back("R1 even read");
    bus(1'b0, 1'b0, 8'h00);

    // R12 plain storage, alarm byte included
    wr_reg(8'h20, 8'h5A);
    wr_reg(8'h01, 8'h30);
    rd_reg(8'h20, 8'h5A, "R12 general byte");
    rd_reg(8'h01, 8'h30, "R12 alarm byte");
    drain();
    chk("R12 no load from storage", load_cnt, 0);
    // R1 only bits 6:0 of the index are kept
    bus(1'b1, 1'b0, 8'hA0);
    exp_q.push_back(8'h5A); tag_q.push_back("R1 index masked");
    bus(1'b0, 1'b1, 8'h00);

    // R2 update-in-progress protection
    wr_reg(8'd10, 8'hFF);
    rd_reg(8'd10, 8'h7F, "R2 A write keeps flag clear");
    pulse(0);
    rd_reg(8'd10, 8'hFF, "R2 flag set by update start");
    wr_reg(8'd10, 8'h26);
    rd_reg(8'd10, 8'hA6, "R2 A write keeps flag set");
    cnt_time = 56'h24_12_31_03_23_59_58;
    pulse(1);
    rd_reg(8'd10, 8'h26, "R2 flag cleared by update done");
    rd_reg(8'd0, 8'h58, "R10 seconds copied");
    rd_reg(8'd9, 8'h24, "R10 year copied");
    rd_reg(8'd12, 8'h10, "R10 update flag, R7 no IRQF");
    drain();
    chk("R7 irq off without enable", irq, 0);

    // R5 time write with set mode off
    lc = load_cnt;
    wr_reg(8'd0, 8'h45);
    step(); step();
    chk("R5 load raised", load_cnt, lc + 1);
    chk("R5 load seconds slot", last_load[7:0], 8'h45);
    chk("R5 load minutes slot", last_load[15:8], 8'h59);

    // R3 set mode forcing
    pulse(0);
    wr_reg(8'd11, 8'h92);
    rd_reg(8'd11, 8'h82, "R3 update enable forced off");
    rd_reg(8'd10, 8'h26, "R3 flag cleared by set mode");
    drain();
    lc = load_cnt;
    wr_reg(8'd2, 8'h12);
    drain();
    chk("R5 no load in set mode", load_cnt, lc);
    rd_reg(8'd2, 8'h12, "R5 minutes stored");
    cnt_time = 56'h24_12_31_03_23_59_11;
    pulse(1);
    rd_reg(8'd0, 8'h45, "R10 no copy in set mode");
    rd_reg(8'd12, 8'h10, "R10 update flag in set mode");
    drain();

    // R4 leaving set mode
    lc = load_cnt;
    wr_reg(8'd11, 8'h02);
    drain();
    chk("R4 load on leaving set", load_cnt, lc + 1);
    chk("R4 load minutes slot", last_load[15:8], 8'h12);
    chk("R4 load seconds slot", last_load[7:0], 8'h45);
    wr_reg(8'd11, 8'h02);
    drain();
    chk("R4 no load when already clear", load_cnt, lc + 1);

    // R6 write-ignored bytes
    wr_reg(8'd12, 8'hFF);
    wr_reg(8'd13, 8'h00);
    rd_reg(8'd12, 8'h00, "R6 C ignores write");
    rd_reg(8'd13, 8'h80, "R6 D ignores write");
    drain();

    // R7/R6 update interrupt and clear-on-read
    wr_reg(8'd11, 8'h12);
    pulse(1);
    chk("R7 irq with update enable", irq, 1);
    rd_reg(8'd12, 8'h90, "R6 C read value");
    drain();
    chk("R6 irq dropped by read", irq, 0);
    rd_reg(8'd12, 8'h00, "R6 C cleared");
    drain();

    // R7 flag before enable
    wr_reg(8'd11, 8'h02);
    pulse(2);
    chk("R7 alarm flag without enable", irq, 0);
    wr_reg(8'd11, 8'h22);
    chk("R7 irq once enabled", irq, 1);
    rd_reg(8'd12, 8'hA0, "R7 alarm flags");
    wr_reg(8'd11, 8'h42);
    pulse(3);
    rd_reg(8'd12, 8'hC0, "R7 periodic flags");
    drain();

    // R11 back-pressure
    bus(1'b1, 1'b0, 8'h20);
    rsp_ready = 1'b0;
    exp_q.push_back(8'h5A); tag_q.push_back("R11 held response");
    bus(1'b0, 1'b1, 8'h00);
    step(); step();
    chk("R11 rsp_valid held", rsp_valid, 1);
    chk("R11 req_ready low", req_ready, 0);
    chk("R11 rsp_data stable", rsp_data, 8'h5A);
    rsp_ready = 1'b1;
    drain();

    // R9 soft reset
    wr_reg(8'd11, 8'h6A);
    pulse(3);
    chk("R9 irq before soft reset", irq, 1);
    pulse(4);
    chk("R9 irq after soft reset", irq, 0);
    rd_reg(8'd11, 8'h02, "R9 B enables cleared");
    rd_reg(8'd12, 8'h00, "R9 C flags cleared");
    rd_reg(8'd10, 8'h26, "R9 A untouched");
    drain();

    report();
    $finish;
  end
endmodule